// File: doc/BRIEF.md
# Cache-Side Atomic Operation Dispatcher

This block sits next to one processor's data cache and carries out atomic read-modify-write requests. Two request forms exist: a load-and-op form, which returns the memory word as it stood before the update, and a store-and-op form, which only applies the update and returns zero. Four update operations are supported: add, bitwise AND, bitwise OR and swap.

For each request the dispatcher first looks up the target line. A line held exclusively is updated in place, and no traffic leaves the processor. Otherwise the operand and operation code go to the memory controller as a no-allocate request, and the dispatcher waits for its response. A line held in shared state is handled by a configuration input. It is either upgraded to exclusive and then updated locally, or dropped from the cache and handled remotely. Requests flagged uncacheable always go remote. The value the processor sees does not depend on which path was taken.

Top module: `atomic_dispatch`

## Requirements
- R1: When the lookup reports the line exclusive (tag state 2'b10), the dispatcher writes the updated word into the cache, raises no memory request, and pulses `done` two clock edges after the accepting edge.
- R2: When the line is absent or invalid (tag state 2'b00), the dispatcher raises a memory request carrying the address, operation code, operand and store flag, and never writes the cache.
- R3: A load-and-op (`req_store`=0) returns the word's previous value on `done_data` with `done`; a store-and-op (`req_store`=1) returns zero.
- R4: Operation codes: 0 adds the operand, 1 ANDs it, 2 ORs it, 3 replaces the word with the operand.
- R5: A shared line (tag state 2'b01) with `cfg_upgrade_shared`=1 raises `upg_req` until `upg_ack`, looks the line up again, and then updates it locally; `done` follows five edges after acceptance when the acknowledge arrives one cycle after the request.
- R6: A shared line with `cfg_upgrade_shared`=0 pulses `line_drop` for the single lookup cycle and is then handled remotely.
- R7: A request with `req_uncached`=1 goes remote whatever the tag state, and leaves the cache untouched; the result matches the cached path.
- R8: `busy` is high from the cycle after acceptance until `done`, and a request presented while busy is ignored.
- R9: `line_hold` is high during the lookup cycle that chose the local path and during the write cycle; every cache write occurs under `line_hold`.
- R10: A memory request holds its fields stable while `mem_req_ready` is low. Completion is signalled on the cycle after `mem_rsp_valid`, for both forms, so remote latency is 2 + stall cycles + response delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_upgrade_shared | input | 1 | 1: upgrade a shared line and work locally; 0: drop it and go remote |
| req_valid | input | 1 | Atomic request strobe, taken only when idle |
| req_store | input | 1 | 1: store-and-op, 0: load-and-op |
| req_uncached | input | 1 | Force the remote path |
| req_op | input | 2 | Operation code |
| req_addr | input | AW | Word address |
| req_operand | input | DW | Register operand |
| busy | output | 1 | A request is in flight |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | DW | Previous value (load form) or zero |
| tag_addr | output | AW | Lookup address to the cache |
| tag_state | input | 2 | Line state: 00 invalid, 01 shared, 10 exclusive |
| cache_rdata | input | DW | Cached word at `tag_addr` |
| cache_we | output | 1 | Write the updated word |
| cache_wdata | output | DW | Updated word |
| line_hold | output | 1 | Hold the line against snoops |
| line_drop | output | 1 | Invalidate the shared line |
| upg_req | output | 1 | Request exclusive ownership |
| upg_ack | input | 1 | Ownership granted |
| mem_req_valid | output | 1 | Remote atomic request valid |
| mem_req_ready | input | 1 | Memory controller accepts |
| mem_req_addr | output | AW | Remote address |
| mem_req_op | output | 2 | Remote operation code |
| mem_req_store | output | 1 | Remote form flag |
| mem_req_operand | output | DW | Remote operand |
| mem_rsp_valid | input | 1 | Remote completion |
| mem_rsp_data | input | DW | Previous value from memory |

## Verification
Latency is counted in edges from the accepting edge. A local exclusive update completes after two edges, an upgraded shared line after five, and a remote request after two plus the stall cycles plus the response delay. The drop pulse appears in the first cycle after acceptance. For every request the bench derives the path from its own cache model. It then checks `busy`, `done`, `line_hold`, `line_drop` and `mem_req_valid` at each falling edge against that schedule, and reads `done_data` exactly in the completion cycle. Cache contents, memory contents and request fields are compared after each request.

// File: rtl/atomic_dispatch.sv
module atomic_dispatch #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_upgrade_shared,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic          req_uncached,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_operand,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] done_data,
  output logic [AW-1:0] tag_addr,
  input  logic [1:0]    tag_state,
  input  logic [DW-1:0] cache_rdata,
  output logic          cache_we,
  output logic [DW-1:0] cache_wdata,
  output logic          line_hold,
  output logic          line_drop,
  output logic          upg_req,
  input  logic          upg_ack,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic [1:0]    mem_req_op,
  output logic          mem_req_store,
  output logic [DW-1:0] mem_req_operand,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam logic [1:0] LN_SHR = 2'b01;
  localparam logic [1:0] LN_EXC = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_UPG, S_RMW, S_SEND, S_WAIT} state_t;

  state_t        st;
  logic          store_q, unc_q, done_q;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] opnd_q, data_q;

  function automatic logic [DW-1:0] apply_op(input logic [1:0] op,
                                             input logic [DW-1:0] old,
                                             input logic [DW-1:0] arg);
    case (op)
      2'd0:    return old + arg;
      2'd1:    return old & arg;
      2'd2:    return old | arg;
      default: return arg;
    endcase
  endfunction

  wire hit_exc = (tag_state == LN_EXC);
  wire hit_shr = (tag_state == LN_SHR);
  wire in_look = (st == S_LOOK);

  assign busy            = (st != S_IDLE);
  assign done            = done_q;
  assign done_data       = data_q;
  assign tag_addr        = addr_q;
  assign cache_we        = (st == S_RMW);
  assign cache_wdata     = apply_op(op_q, cache_rdata, opnd_q);
  assign line_hold       = (st == S_RMW) || (in_look && !unc_q && hit_exc);
  assign line_drop       = in_look && !unc_q && hit_shr && !cfg_upgrade_shared;
  assign upg_req         = (st == S_UPG);
  assign mem_req_valid   = (st == S_SEND);
  assign mem_req_addr    = addr_q;
  assign mem_req_op      = op_q;
  assign mem_req_store   = store_q;
  assign mem_req_operand = opnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      store_q <= 1'b0;
      unc_q   <= 1'b0;
      done_q  <= 1'b0;
      op_q    <= '0;
      addr_q  <= '0;
      opnd_q  <= '0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          store_q <= req_store;
          unc_q   <= req_uncached;
          op_q    <= req_op;
          addr_q  <= req_addr;
          opnd_q  <= req_operand;
          st      <= S_LOOK;
        end
        S_LOOK: begin
          if (unc_q)                          st <= S_SEND;
          else if (hit_exc)                   st <= S_RMW;
          else if (hit_shr && cfg_upgrade_shared) st <= S_UPG;
          else                                st <= S_SEND;
        end
        S_UPG: if (upg_ack) st <= S_LOOK;
        S_RMW: begin
          done_q <= 1'b1;
          data_q <= store_q ? '0 : cache_rdata;
          st     <= S_IDLE;
        end
        S_SEND: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          done_q <= 1'b1;
          data_q <= store_q ? '0 : mem_rsp_data;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module atomic_dispatch_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [1:0]    tag_state,
  input logic          cache_we,
  input logic          line_hold,
  input logic          upg_req,
  input logic          upg_ack,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic [1:0]    mem_req_op,
  input logic [DW-1:0] mem_req_operand
);
  assert_write_on_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cache_we |-> tag_state == 2'b10);

  assert_no_write_with_remote_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cache_we |-> !mem_req_valid);

  assert_upgrade_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upg_req && !upg_ack |=> upg_req);

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_write_under_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cache_we |-> line_hold);

  assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_op) && $stable(mem_req_operand));
endmodule

bind atomic_dispatch atomic_dispatch_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_atomic_dispatch.sv
module test_atomic_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_upgrade_shared = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_uncached = 1'b0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_addr = '0, req_operand = '0;
  logic        busy, done, cache_we, line_hold, line_drop, upg_req;
  logic [31:0] done_data, tag_addr, cache_wdata, cache_rdata;
  logic [1:0]  tag_state;
  logic        upg_ack = 1'b0;
  logic        mem_req_valid, mem_req_store;
  logic        mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_req_operand, mem_rsp_data;
  logic [1:0]  mem_req_op;

  always #4 clk = ~clk;

  atomic_dispatch i_atomic_dispatch (.*);

  integer checks = 0, failures = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_op(input logic [1:0] op, input logic [31:0] a,
                                         input logic [31:0] b);
    if (op == 2'd0) return a + b;
    if (op == 2'd1) return a & b;
    if (op == 2'd2) return a | b;
    return b;
  endfunction

  // cache model
  logic [27:0] ln_tag [4];
  logic [1:0]  ln_state [4];
  logic [31:0] ln_data [4];
  integer      we_cnt = 0;
  logic        pl_en = 1'b0;
  logic [1:0]  pl_idx = '0, pl_state = '0;
  logic [27:0] pl_tag = '0;
  logic [31:0] pl_data = '0;

  assign tag_state   = (ln_tag[tag_addr[3:2]] == tag_addr[31:4]) ? ln_state[tag_addr[3:2]] : 2'b00;
  assign cache_rdata = ln_data[tag_addr[3:2]];

  always @(posedge clk) begin
    if (pl_en) begin
      ln_tag[pl_idx]   <= pl_tag;
      ln_state[pl_idx] <= pl_state;
      ln_data[pl_idx]  <= pl_data;
    end
    if (cache_we) begin
      ln_data[tag_addr[3:2]] <= cache_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (line_drop) ln_state[tag_addr[3:2]] <= 2'b00;
    if (upg_req && !upg_ack) ln_state[tag_addr[3:2]] <= 2'b10;
    upg_ack <= upg_req && !upg_ack;
  end

  // memory-side responder
  logic [31:0] mem [4];
  integer      rem_cnt = 0, stall_cfg = 0, dly_cfg = 1;
  logic [31:0] cap_addr, cap_opnd;
  logic [1:0]  cap_op;
  logic        cap_store;

  initial begin : responder
    bit pend;
    int sl;
    logic [31:0] old;
    pend = 0; sl = 0;
    mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    for (int i = 0; i < 4; i++) mem[i] = 32'hA000_0000 + i * 32'h111;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        if (!pend) begin pend = 1; sl = stall_cfg; end
        if (sl > 0) begin
          mem_req_ready = 1'b0;
          sl--;
        end else begin
          pend = 0;
          mem_req_ready = 1'b1;
          cap_addr = mem_req_addr; cap_op = mem_req_op;
          cap_store = mem_req_store; cap_opnd = mem_req_operand;
          rem_cnt++;
          old = mem[mem_req_addr[3:2]];
          mem[mem_req_addr[3:2]] = ref_op(mem_req_op, old, mem_req_operand);
          @(posedge clk);
          repeat (dly_cfg) @(negedge clk);
          mem_rsp_valid = 1'b1; mem_rsp_data = old;
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  localparam logic [27:0] TAG = 28'h0012340;

  task automatic preload(input logic [1:0] idx, input logic [27:0] tg,
                         input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_idx = idx; pl_tag = tg; pl_state = s; pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic do_op(input bit sf, input bit unc, input logic [1:0] op,
                       input logic [31:0] addr, input logic [31:0] opnd,
                       input bit cfg, input int s, input int d, input bit poke);
    int idx, path, lat, we0, rc0;
    logic [1:0] lst;
    logic [31:0] old, cdata0;
    idx = addr[3:2];
    lst = (ln_tag[idx] == addr[31:4]) ? ln_state[idx] : 2'b00;
    if (unc) path = 2;
    else if (lst == 2'b10) path = 0;
    else if (lst == 2'b01 && cfg) path = 1;
    else path = 2;
    lat = (path == 0) ? 2 : (path == 1) ? 5 : 2 + s + d;
    old = (path == 2) ? mem[idx] : ln_data[idx];
    cdata0 = ln_data[idx];
    we0 = we_cnt; rc0 = rem_cnt;
    stall_cfg = s; dly_cfg = d;
    @(negedge clk);
    cfg_upgrade_shared = cfg;
    req_valid = 1'b1; req_store = sf; req_uncached = unc; req_op = op;
    req_addr = addr; req_operand = opnd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n <= lat + 1; n++) begin
      if (poke && n == 1) begin
        req_valid = 1'b1; req_addr = addr ^ 32'h0000_0100; req_uncached = 1'b1;
      end
      if (poke && n == 2) req_valid = 1'b0;
      chk(busy == (n < lat), "R8", "busy", busy, n < lat);
      chk(done == (n == lat), (path == 0) ? "R1" : (path == 1) ? "R5" : "R10", "done", done, n == lat);
      chk(line_hold == ((path == 0 && n < 2) || (path == 1 && (n == 3 || n == 4))), "R9",
          "line_hold", line_hold, 0);
      chk(line_drop == (path == 2 && !unc && lst == 2'b01 && n == 0), "R6", "line_drop", line_drop, 0);
      chk(mem_req_valid == (path == 2 && n >= 1 && n <= 1 + s), "R2", "mem_req_valid",
          mem_req_valid, 0);
      if (n == lat)
        chk(done_data == (sf ? 32'h0 : old), "R3", "done_data", done_data, sf ? 32'h0 : old);
      @(negedge clk);
    end
    if (path == 2) begin
      chk(rem_cnt == rc0 + 1, unc ? "R7" : "R2", "remote count", rem_cnt, rc0 + 1);
      chk(we_cnt == we0, "R2", "cache writes", we_cnt, we0);
      chk(mem[idx] == ref_op(op, old, opnd), "R4", "memory word", mem[idx], ref_op(op, old, opnd));
      chk(cap_addr == addr && cap_op == op && cap_store == sf && cap_opnd == opnd, "R10",
          "request fields", cap_addr, addr);
      chk(ln_data[idx] == cdata0, "R2", "cache word kept", ln_data[idx], cdata0);
      if (unc) chk(ln_state[idx] == lst, "R7", "line state kept", ln_state[idx], lst);
      else if (lst == 2'b01) chk(ln_state[idx] == 2'b00, "R6", "line dropped", ln_state[idx], 0);
    end else begin
      chk(rem_cnt == rc0, "R1", "no remote", rem_cnt, rc0);
      chk(we_cnt == we0 + 1, "R1", "cache writes", we_cnt, we0 + 1);
      chk(ln_data[idx] == ref_op(op, old, opnd), "R4", "cache word", ln_data[idx],
          ref_op(op, old, opnd));
      if (path == 1) chk(ln_state[idx] == 2'b10, "R5", "upgraded", ln_state[idx], 2'b10);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!busy && !done && !mem_req_valid && !cache_we && !upg_req, "R8", "reset idle",
        {busy, done, mem_req_valid, cache_we, upg_req}, 0);
    preload(2'd0, TAG, 2'b10, 32'd5);
    preload(2'd1, TAG, 2'b01, 32'h0000_0100);
    preload(2'd2, TAG, 2'b00, 32'h5555_5555);
    preload(2'd3, TAG, 2'b10, 32'hFFFF_00F0);

    do_op(0, 0, 2'd0, {TAG, 2'd0, 2'b00}, 32'd3, 0, 0, 1, 0);          // R1 load add
    do_op(1, 0, 2'd1, {TAG, 2'd3, 2'b00}, 32'h0F0F_0FFF, 0, 0, 1, 0);  // R3 store and
    do_op(0, 0, 2'd2, {TAG, 2'd0, 2'b00}, 32'h8000_0000, 0, 0, 1, 0);  // R4 or
    do_op(0, 0, 2'd3, {TAG, 2'd0, 2'b00}, 32'h1234_5678, 0, 0, 1, 0);  // R4 swap
    do_op(0, 0, 2'd0, {TAG, 2'd2, 2'b00}, 32'd7, 0, 0, 1, 0);          // R2 remote add
    do_op(1, 0, 2'd2, {TAG, 2'd2, 2'b00}, 32'h00F0_0000, 0, 2, 3, 1);  // R8 R10 stall, poke
    do_op(0, 0, 2'd3, {TAG, 2'd1, 2'b00}, 32'hCAFE_0001, 1, 0, 1, 0);  // R5 upgrade
    preload(2'd1, TAG, 2'b01, 32'h0000_0200);
    do_op(0, 0, 2'd0, {TAG, 2'd1, 2'b00}, 32'd1, 0, 0, 2, 0);          // R6 drop and remote
    do_op(0, 1, 2'd0, {TAG, 2'd3, 2'b00}, 32'd9, 0, 1, 1, 0);          // R7 uncached
    do_op(0, 0, 2'd1, {28'h0ABCDE0, 2'd0, 2'b00}, 32'hFF00_FF00, 0, 0, 1, 0); // R2 tag miss
    do_op(1, 0, 2'd0, {TAG, 2'd0, 2'b00}, 32'd2, 1, 0, 1, 0);          // R3 store local

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule